// File: doc/BRIEF.md
# Bitstream Configuration Loader

This block accepts an FPGA configuration image from a host bus and streams it, one byte per clock, into the byte-wide configuration port of a target device. The host writes 32-bit words into a word FIFO through a fixed data address. Words can come from the CPU, which polls the FIFO fill, or from an external DMA controller. In the DMA case the block paces the controller with a request line that asks for bursts of half the FIFO at a time.

Before enabling, software programs the total image length in bytes. The engine counts every byte it hands to the target and stops at that total. It watches the target's error and done inputs. The interrupt rises when the target reports done after the full length has been sent, or when an error is seen. Software ends the session by writing zero to the control register, which stops the engine, empties the FIFO and clears the interrupt. The target is reset by writing the enable and reset bits together and then writing zero.

Top module: `bitload_engine`

## Requirements
- R1: After reset the engine is disabled. Control (0x40), status (0x44), fill (0x4C), total (0x50) and consumed count (0x54) all read 0. `irq`, `cfg_valid`, `tgt_reset` and `dma_req` are low.
- R2: Control at 0x40 has three bits: bit 0 enable, bit 1 target reset, bit 2 DMA pacing. The register reads back what was written. `tgt_reset` is high in every cycle where enable and reset are both set.
- R3: A write to 0x3000 while enabled and not full puts the word into the FIFO. Offset 0x48 reads the capacity in bytes (4 × FIFO_WORDS, which is 32 by default). Offset 0x4C reads the bytes currently held in the FIFO.
- R4: A data write while the FIFO is full, or while the engine is disabled, is dropped and sets the sticky overflow flag, status bit 2. When this happens while enabled, it raises `irq` and halts output.
- R5: A word leaves the FIFO only when the shifter is empty and the engine may run. Its four bytes then appear on `cfg_data`, most significant byte first, with `cfg_valid` high, in the four cycles after that.
- R6: The consumed count at 0x54 goes up by one for each byte sent. It is cleared when enable is written 1 while the engine is disabled. No byte is sent once the count equals the total at 0x50.
- R7: When the count equals the total, no error is flagged and `tgt_done` is high, status bit 0 is latched. `irq` rises one cycle later.
- R8: `tgt_err` while enabled latches status bit 1 and raises `irq`. No byte is sent from the next cycle onward.
- R9: Writing control with bit 0 clear drives `irq` low in the next cycle, stops output and empties the FIFO one cycle later.
- R10: `dma_req` is high only when all of the following hold: the engine is enabled in DMA mode, no error is flagged, at least half the FIFO is free, and the total exceeds consumed plus FIFO bytes plus bytes held in the shifter.
- R11: Status bit 18 follows `tgt_done` directly, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register or data write strobe |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cfg_valid | output | 1 | A configuration byte is presented this cycle |
| cfg_data | output | 8 | Configuration byte |
| tgt_reset | output | 1 | Reset/reconfigure request to the target |
| tgt_err | input | 1 | Target reports a configuration error |
| tgt_done | input | 1 | Target reports configuration done |
| dma_req | output | 1 | Request for a burst of FIFO_WORDS/2 words |
| irq | output | 1 | Completion or error interrupt |

## Verification
A register write shows up on `bus_rdata` one clock edge after the write. A popped word puts its first byte out in the cycle after the pop. `irq` and the status flags follow the triggering input by one edge. `dma_req` and `tgt_reset` are combinational from the registered state, so they change in the same cycle as that state. The bench drives inputs just after the rising edge and compares outputs against a behavioural model at the falling edge of each cycle. With this timing, every one-edge delay above lands exactly on the sample point.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = BUS_W / BYTE_W;

  localparam int unsigned OFF_CTRL  = 'h40;
  localparam int unsigned OFF_STAT  = 'h44;
  localparam int unsigned OFF_SIZE  = 'h48;
  localparam int unsigned OFF_USED  = 'h4C;
  localparam int unsigned OFF_TOTAL = 'h50;
  localparam int unsigned OFF_COUNT = 'h54;
  localparam int unsigned OFF_DATA  = 'h3000;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_RST = 1;
  localparam int unsigned CTL_DMA = 2;

  localparam int unsigned ST_FIN   = 0;
  localparam int unsigned ST_TERR  = 1;
  localparam int unsigned ST_OVF   = 2;
  localparam int unsigned ST_TDONE = 18;

  typedef struct packed {
    logic dma;
    logic rst;
    logic en;
  } ctrl_t;

  function automatic logic [BUS_W-1:0] words_to_bytes(input logic [BUS_W-1:0] words);
    return words << 2;
  endfunction

  function automatic logic still_uncovered(input logic [BUS_W-1:0] total,
                                           input logic [BUS_W-1:0] consumed,
                                           input logic [BUS_W-1:0] queued_bytes,
                                           input logic [BUS_W-1:0] held_bytes);
    logic [BUS_W+1:0] covered;
    covered = {2'b00, consumed} + {2'b00, queued_bytes} + {2'b00, held_bytes};
    return {2'b00, total} > covered;
  endfunction
endpackage

// File: rtl/bl_fifo.sv
module bl_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/bl_shifter.sv
module bl_shifter #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int HELD_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic              word_avail,
  input  logic [WORD_W-1:0] word_in,
  output logic              take,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out,
  output logic [HELD_W-1:0] held
);
  localparam int NBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] sh_q;
  logic [HELD_W-1:0] left_q;

  assign byte_valid = (left_q != '0) && run;
  assign take       = (left_q == '0) && run && word_avail;
  assign byte_out   = sh_q[WORD_W-1 -: BYTE_W];
  assign held       = left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (clear) begin
      left_q <= '0;
    end else if (take) begin
      sh_q   <= word_in;
      left_q <= HELD_W'(NBYTES);
    end else if (byte_valid) begin
      sh_q   <= sh_q << BYTE_W;
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/bl_dmareq.sv
module bl_dmareq #(
  parameter int FIFO_WORDS = 8,
  parameter int FCNT_W     = 4,
  parameter int HELD_W     = 3
) (
  input  logic              en,
  input  logic              dma_mode,
  input  logic              halted,
  input  logic [FCNT_W-1:0] fifo_words,
  input  logic [HELD_W-1:0] held,
  input  logic [31:0]       total,
  input  logic [31:0]       consumed,
  output logic              req
);
  import bl_pkg::*;

  localparam int HALF = FIFO_WORDS / 2;

  logic [FCNT_W-1:0] free_words;
  logic              room, pending;

  assign free_words = FCNT_W'(FIFO_WORDS) - fifo_words;
  assign room       = free_words >= FCNT_W'(HALF);
  assign pending    = still_uncovered(total, consumed,
                                      words_to_bytes(32'(fifo_words)), 32'(held));
  assign req        = en && dma_mode && !halted && room && pending;
endmodule

// File: rtl/bitload_engine.sv
module bitload_engine #(
  parameter int FIFO_WORDS = 8,
  parameter int ADDR_W     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cfg_valid,
  output logic [7:0]        cfg_data,
  output logic              tgt_reset,
  input  logic              tgt_err,
  input  logic              tgt_done,
  output logic              dma_req,
  output logic              irq
);
  import bl_pkg::*;

  localparam int FCNT_W = $clog2(FIFO_WORDS + 1);
  localparam int HELD_W = $clog2(WORD_BYTES + 1);

  ctrl_t       ctrl_q;
  logic [31:0] total_q, consumed_q;
  logic        err_tgt_q, err_ovf_q, fin_q, irq_q;

  logic wr_ctrl, wr_total, wr_data, en_rise, dis_wr;
  logic eng_en, dma_mode, halted, run, accept, drop, done_hit, irq_set;
  logic fifo_full, fifo_empty, take;
  logic [FCNT_W-1:0] fifo_words;
  logic [31:0]       head;
  logic [HELD_W-1:0] held;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_total = bus_wr && (bus_addr == ADDR_W'(OFF_TOTAL));
  assign wr_data  = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign eng_en   = ctrl_q.en;
  assign dma_mode = ctrl_q.dma;
  assign en_rise  = wr_ctrl && bus_wdata[CTL_EN] && !eng_en;
  assign dis_wr   = wr_ctrl && !bus_wdata[CTL_EN];
  assign halted   = err_tgt_q || err_ovf_q;
  assign run      = eng_en && !halted && (consumed_q < total_q);
  assign accept   = wr_data && eng_en && !fifo_full;
  assign drop     = wr_data && !accept;
  assign done_hit = eng_en && !halted && (consumed_q == total_q) && tgt_done;
  assign irq_set  = eng_en && (done_hit || tgt_err || drop);

  bl_fifo #(.DEPTH(FIFO_WORDS), .WIDTH(32), .CNT_W(FCNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!eng_en), .push(accept), .din(bus_wdata),
    .pop(take), .dout(head), .count(fifo_words), .full(fifo_full), .empty(fifo_empty)
  );

  bl_shifter #(.WORD_W(32), .BYTE_W(8), .HELD_W(HELD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(!eng_en), .run(run), .word_avail(!fifo_empty),
    .word_in(head), .take(take), .byte_valid(cfg_valid), .byte_out(cfg_data), .held(held)
  );

  bl_dmareq #(.FIFO_WORDS(FIFO_WORDS), .FCNT_W(FCNT_W), .HELD_W(HELD_W)) u_dma (
    .en(eng_en), .dma_mode(dma_mode), .halted(halted), .fifo_words(fifo_words),
    .held(held), .total(total_q), .consumed(consumed_q), .req(dma_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      total_q    <= '0;
      consumed_q <= '0;
      err_tgt_q  <= 1'b0;
      err_ovf_q  <= 1'b0;
      fin_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[2:0]);
      if (wr_total) total_q <= bus_wdata;

      if (en_rise)        consumed_q <= '0;
      else if (cfg_valid) consumed_q <= consumed_q + 1'b1;

      if (en_rise)                 err_tgt_q <= 1'b0;
      else if (eng_en && tgt_err)  err_tgt_q <= 1'b1;

      if (en_rise)   err_ovf_q <= 1'b0;
      else if (drop) err_ovf_q <= 1'b1;

      if (en_rise)       fin_q <= 1'b0;
      else if (done_hit) fin_q <= 1'b1;

      if (dis_wr)       irq_q <= 1'b0;
      else if (irq_set) irq_q <= 1'b1;
    end
  end

  assign irq       = irq_q;
  assign tgt_reset = ctrl_q.en && ctrl_q.rst;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_CTRL):  bus_rdata = {29'd0, ctrl_q.dma, ctrl_q.rst, ctrl_q.en};
      ADDR_W'(OFF_STAT): begin
        bus_rdata[ST_FIN]   = fin_q;
        bus_rdata[ST_TERR]  = err_tgt_q;
        bus_rdata[ST_OVF]   = err_ovf_q;
        bus_rdata[ST_TDONE] = tgt_done;
      end
      ADDR_W'(OFF_SIZE):  bus_rdata = words_to_bytes(32'(FIFO_WORDS));
      ADDR_W'(OFF_USED):  bus_rdata = words_to_bytes(32'(fifo_words));
      ADDR_W'(OFF_TOTAL): bus_rdata = total_q;
      ADDR_W'(OFF_COUNT): bus_rdata = consumed_q;
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
  parameter int FIFO_WORDS = 8,
  parameter int ADDR_W     = 14,
  parameter int FCNT_W     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              eng_en,
  input logic              dma_mode,
  input logic [FCNT_W-1:0] fifo_words,
  input logic              cfg_valid,
  input logic [31:0]       consumed_q,
  input logic [31:0]       total_q,
  input logic              irq,
  input logic              tgt_err,
  input logic              tgt_reset,
  input logic              dma_req,
  input logic              err_ovf_q
);
  import bl_pkg::*;

  logic data_wr, ctrl_off_wr;
  assign data_wr     = bus_wr && (bus_addr == ADDR_W'(OFF_DATA));
  assign ctrl_off_wr = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL)) && !bus_wdata[CTL_EN];

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_words <= FCNT_W'(FIFO_WORDS)); // R3
  AST_DROP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !eng_en) |=> err_ovf_q); // R4
  AST_BYTE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> eng_en); // R5
  AST_COUNT_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (consumed_q < total_q)); // R6
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && tgt_err) |=> !cfg_valid); // R8
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_off_wr |=> !irq); // R9
  AST_DMA_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (eng_en && dma_mode && (FCNT_W'(FIFO_WORDS) - fifo_words) >= FCNT_W'(FIFO_WORDS / 2))); // R10
  AST_RESET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_reset |-> eng_en); // R2
endmodule

bind bitload_engine bl_checker #(
  .FIFO_WORDS(FIFO_WORDS), .ADDR_W(ADDR_W), .FCNT_W(FCNT_W)
) u_bl_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .eng_en(eng_en), .dma_mode(dma_mode), .fifo_words(fifo_words), .cfg_valid(cfg_valid),
  .consumed_q(consumed_q), .total_q(total_q), .irq(irq), .tgt_err(tgt_err),
  .tgt_reset(tgt_reset), .dma_req(dma_req), .err_ovf_q(err_ovf_q)
);

// File: tb/test_bitload_engine.sv
`timescale 1ns/1ps
module test_bitload_engine;
  localparam int DEPTH = 8;
  localparam logic [13:0] A_CTRL = 14'h0040, A_STAT = 14'h0044, A_SIZE = 14'h0048,
                          A_USED = 14'h004C, A_TOTAL = 14'h0050, A_CNT = 14'h0054,
                          A_DATA = 14'h3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [13:0] bus_addr = A_CNT;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cfg_valid, tgt_reset, dma_req, irq;
  logic [7:0] cfg_data;
  logic tgt_err = 1'b0, tgt_done = 1'b0;

  int vectors = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bitload_engine i_bitload_engine (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cfg_valid(cfg_valid), .cfg_data(cfg_data), .tgt_reset(tgt_reset),
    .tgt_err(tgt_err), .tgt_done(tgt_done), .dma_req(dma_req), .irq(irq)
  );

  // behavioural reference
  logic [31:0] mq[$];
  logic [31:0] m_word;
  int m_left;
  bit m_en, m_rst, m_dma, m_terr, m_ovf, m_fin, m_irq;
  longint m_total, m_cons;
  logic [7:0] seen[$];

  function automatic bit m_run();
    return m_en && !m_terr && !m_ovf && (m_cons < m_total);
  endfunction

  function automatic logic [31:0] m_read(input logic [13:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      A_CTRL:  r = {29'd0, m_dma, m_rst, m_en};
      A_STAT:  begin r[0] = m_fin; r[1] = m_terr; r[2] = m_ovf; r[18] = tgt_done; end
      A_SIZE:  r = DEPTH * 4;
      A_USED:  r = mq.size() * 4;
      A_TOTAL: r = m_total[31:0];
      A_CNT:   r = m_cons[31:0];
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_word = '0; m_left = 0;
      m_en = 0; m_rst = 0; m_dma = 0; m_terr = 0; m_ovf = 0; m_fin = 0; m_irq = 0;
      m_total = 0; m_cons = 0;
    end else begin
      bit run, fire, pop, dw, acc, ovf, donec, cw, rise, en_now;
      logic [31:0] hd;
      run    = m_run();
      fire   = (m_left != 0) && run;
      pop    = (m_left == 0) && run && (mq.size() != 0);
      dw     = bus_wr && bus_addr == A_DATA;
      acc    = dw && m_en && mq.size() < DEPTH;
      ovf    = dw && !acc;
      donec  = m_en && !m_terr && !m_ovf && (m_cons == m_total) && tgt_done;
      cw     = bus_wr && bus_addr == A_CTRL;
      rise   = cw && bus_wdata[0] && !m_en;
      en_now = m_en;
      if (!en_now) begin mq.delete(); m_left = 0; end
      else begin
        if (pop) begin hd = mq.pop_front(); m_word = hd; m_left = 4; end
        else if (fire) begin m_word = m_word << 8; m_left--; end
        if (acc) mq.push_back(bus_wdata);
      end
      if (rise) m_cons = 0; else if (fire) m_cons++;
      if (rise) m_terr = 0; else if (en_now && tgt_err) m_terr = 1;
      if (rise) m_ovf = 0; else if (ovf) m_ovf = 1;
      if (rise) m_fin = 0; else if (donec) m_fin = 1;
      if (cw && !bus_wdata[0]) m_irq = 0;
      else if (en_now && (donec || tgt_err || ovf)) m_irq = 1;
      if (bus_wr && bus_addr == A_TOTAL) m_total = bus_wdata;
      if (cw) begin m_en = bus_wdata[0]; m_rst = bus_wdata[1]; m_dma = bus_wdata[2]; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ev;
      longint cov;
      ev = (m_left != 0) && m_run();
      chk("R5 cfg_valid", {31'd0, cfg_valid}, {31'd0, ev});
      if (ev) chk("R5 cfg_data", {24'd0, cfg_data}, {24'd0, m_word[31:24]});
      chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
      chk("R2 tgt_reset", {31'd0, tgt_reset}, {31'd0, m_en && m_rst});
      cov = m_cons + 4 * mq.size() + m_left;
      chk("R10 dma_req", {31'd0, dma_req},
          {31'd0, m_en && m_dma && !m_terr && !m_ovf && (DEPTH - mq.size()) >= DEPTH / 2 && m_total > cov});
      chk("R3 readback", bus_rdata, m_read(bus_addr));
      if (cfg_valid) seen.push_back(cfg_data);
    end
  end

  // stimulus helpers: every task starts and ends just after a rising edge
  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = A_CNT;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rd(input string tag, input logic [13:0] a, input logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
    @(posedge clk); #1;
    bus_addr = A_CNT;
  endtask

  task automatic pin(input string tag, input logic act_sel, input logic exp);
    chk(tag, {31'd0, act_sel}, {31'd0, exp});
  endtask

  task automatic summary();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd("R1 ctrl", A_CTRL, 32'h0);
    rd("R1 status", A_STAT, 32'h0);
    rd("R1 count", A_CNT, 32'h0);
    @(negedge clk);
    pin("R1 irq", irq, 1'b0); pin("R1 dma_req", dma_req, 1'b0); pin("R1 cfg_valid", cfg_valid, 1'b0);
    @(posedge clk); #1;
    rd("R3 size", A_SIZE, 32'd32);

    // R4 drop while disabled
    wr(A_DATA, 32'h1234_5678);
    rd("R4 ovf when disabled", A_STAT, 32'h4);
    rd("R3 used after drop", A_USED, 32'h0);

    // R2 target reset pulse
    wr(A_CTRL, 32'h3);
    @(negedge clk); pin("R2 reset high", tgt_reset, 1'b1); @(posedge clk); #1;
    rd("R2 ctrl readback", A_CTRL, 32'h3);
    wr(A_CTRL, 32'h0);
    @(negedge clk); pin("R2 reset low", tgt_reset, 1'b0); @(posedge clk); #1;

    // CPU load of 12 bytes
    wr(A_TOTAL, 32'd12);
    wr(A_CTRL, 32'h1);
    rd("R6 flags cleared on enable", A_STAT, 32'h0);
    seen.delete();
    wr(A_DATA, 32'hA1B2_C3D4);
    wr(A_DATA, 32'h5566_7788);
    wr(A_DATA, 32'h99AA_BBCC);
    idle(30);
    rd("R6 consumed", A_CNT, 32'd12);
    rd("R3 drained", A_USED, 32'd0);
    chk("R5 byte count", seen.size(), 12);
    if (seen.size() >= 5) begin
      chk("R5 msb first", {24'd0, seen[0]}, 32'hA1);
      chk("R5 lsb last", {24'd0, seen[3]}, 32'hD4);
      chk("R5 next word", {24'd0, seen[4]}, 32'h55);
    end
    tgt_done = 1'b1;
    idle(2);
    @(negedge clk); pin("R7 irq on done", irq, 1'b1); @(posedge clk); #1;
    rd("R7 R11 status", A_STAT, 32'h0004_0001);
    wr(A_CTRL, 32'h0);
    @(negedge clk); pin("R9 irq cleared", irq, 1'b0); @(posedge clk); #1;
    tgt_done = 1'b0;
    rd("R11 done follows pin", A_STAT, 32'h1);

    // R4 overflow while enabled
    wr(A_TOTAL, 32'd400);
    wr(A_CTRL, 32'h1);
    for (int k = 0; k < 12; k++) wr(A_DATA, 32'h0101_0101 * k);
    idle(1);
    rd("R4 ovf flag", A_STAT, 32'h4);
    @(negedge clk); pin("R4 irq", irq, 1'b1); pin("R4 halted", cfg_valid, 1'b0); @(posedge clk); #1;
    wr(A_CTRL, 32'h0);
    idle(1);
    rd("R9 fifo flushed", A_USED, 32'h0);

    // R8 target error
    wr(A_TOTAL, 32'd64);
    wr(A_CTRL, 32'h1);
    wr(A_DATA, 32'hDEAD_BEEF);
    wr(A_DATA, 32'hCAFE_F00D);
    idle(3);
    tgt_err = 1'b1;
    idle(1);
    tgt_err = 1'b0;
    idle(2);
    rd("R8 err flag", A_STAT, 32'h2);
    @(negedge clk); pin("R8 irq", irq, 1'b1); pin("R8 stopped", cfg_valid, 1'b0); @(posedge clk); #1;
    wr(A_CTRL, 32'h0);

    // R10 DMA paced load
    wr(A_TOTAL, 32'd64);
    wr(A_CTRL, 32'h5);
    @(negedge clk); pin("R10 first request", dma_req, 1'b1); @(posedge clk); #1;
    begin
      int sent;
      sent = 0;
      for (int k = 0; k < 800 && sent < 16; k++) begin
        @(negedge clk);
        if (dma_req) begin
          @(posedge clk); #1;
          for (int b = 0; b < DEPTH / 2; b++) wr(A_DATA, 32'h1000_0000 + sent + b);
          sent += DEPTH / 2;
        end else begin
          @(posedge clk); #1;
        end
      end
      chk("R10 words sent", sent, 16);
    end
    idle(100);
    rd("R6 dma consumed", A_CNT, 32'd64);
    @(negedge clk); pin("R10 covered", dma_req, 1'b0); @(posedge clk); #1;
    wr(A_CTRL, 32'h0);

    // R6 total stops mid-word
    wr(A_TOTAL, 32'd6);
    wr(A_CTRL, 32'h1);
    wr(A_DATA, 32'h0A0B_0C0D);
    wr(A_DATA, 32'h0E0F_1011);
    idle(20);
    rd("R6 stop at total", A_CNT, 32'd6);
    @(negedge clk); pin("R6 no more bytes", cfg_valid, 1'b0); @(posedge clk); #1;
    wr(A_CTRL, 32'h0);
    idle(2);
    summary();
  end
endmodule